// File: doc/BRIEF.md
# Cell Under-Voltage Protection Controller

This block is a synchronous state machine that guards a multi-cell battery pack against over-discharge. It receives already-synchronized per-cell comparator flags for three thresholds: under-voltage, release and charge-enable. It also receives a charger-presence flag, a cell-charge-enable configuration bit, a monitor-mode flag, a sample tick and single-bit host writes. From these it drives the charge and discharge FET enables, a sleep request, a host-access enable and a busy flag. All delays are parameters counted in clock ticks.

A cell that stays low past the detection delay puts the pack into protection. Both FETs open, the block requests sleep and host access is cut. The pack wakes when a charger appears, and a reset lockout then runs. After the lockout the charge path is either blocked or handed to the host. The pack leaves protection through a release delay in monitor mode, or through two qualifying sample ticks outside it. After recovery, the host must re-arm the discharge FET explicitly.

States: `ST_RUN` (normal), `ST_DETECT` (detection delay running), `ST_SLEEP` (protected, asleep), `ST_LOCK` (post-wake lockout), `ST_BLOCK` (charging blocked), `ST_WAIT` (protected, awake), `ST_RELEASE` (release qualification).

Transitions:
- RUN→DETECT when any cell is low.
- DETECT→RUN when no cell is low.
- DETECT→SLEEP when the delay expires.
- SLEEP→LOCK when the charger is present.
- LOCK→BLOCK when the lockout ends with cell-charge-enable set and some cell below the charge-enable threshold.
- LOCK→WAIT when the lockout ends in any other case.
- BLOCK→WAIT when the configuration bit is cleared.
- WAIT→RELEASE when all cells are above the release threshold.
- RELEASE→WAIT when any cell drops back.
- RELEASE→RUN when qualification completes.

Top module: `uvp_guard`

## Requirements
- R1: After reset both FET enables are 1, host_en is 1, and sleep_req and busy are 0.
- R2: When a bit of cell_low is set, sleep_req stays 0 for UV_TICKS cycles. Protection is entered at the (UV_TICKS+1)-th rising edge, provided cell_low is nonzero at every edge up to it. If cell_low clears earlier, the block stays in normal mode.
- R3: On entering protection, cfet_on and dfet_on go to 0, sleep_req goes to 1 and host_en goes to 0, all in the same cycle.
- R4: While asleep, the block stays asleep until chg_present is 1. On the next edge host_en returns to 1 and dfet_on stays 0.
- R5: After wake, busy is 1 for exactly LOCK_TICKS = max(OV_TICKS, UV_TICKS) + GUARD_TICKS cycles. Both FETs stay off during this time, and host writes are ignored.
- R6: If, when the lockout ends, ce_cfg is 1 and some bit of cell_ce_ok is 0, both FETs are held off and charge writes are ignored until ce_cfg is 0. Otherwise the block goes to the awake-protected state.
- R7: In the awake-protected or release states, a write with wr_sel=0 (the charge bit) and wr_val=1 sets cfet_on on the next edge.
- R8: In every protected state, a write with wr_sel=1 (the discharge bit) leaves dfet_on at 0.
- R9: In monitor mode (mon_mode=1), protection ends REL_TICKS+1 edges after cell_rel becomes all ones, if it stays all ones throughout. A drop restarts the qualification.
- R10: With mon_mode=0, protection ends at the second sample_tick pulse that is sampled while cell_rel stays all ones since the release state was entered. A single pulse is not enough.
- R11: After recovery, dfet_on stays 0 until a write with wr_sel=1 and wr_val=1 in normal mode sets it. cfet_on keeps its value, and a later drop of chg_present does not cause sleep again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cell_low | input | NCELL | bit i set: cell i below under-voltage threshold |
| cell_rel | input | NCELL | bit i set: cell i above release threshold |
| cell_ce_ok | input | NCELL | bit i set: cell i above charge-enable threshold |
| chg_present | input | 1 | supply above return-from-sleep level |
| ce_cfg | input | 1 | cell-charge-enable configuration bit |
| mon_mode | input | 1 | monitor mode active |
| sample_tick | input | 1 | single-cycle recovery sample strobe |
| wr_en | input | 1 | host write strobe |
| wr_sel | input | 1 | 0 = charge-FET bit, 1 = discharge-FET bit |
| wr_val | input | 1 | value written |
| cfet_on | output | 1 | charge FET enable |
| dfet_on | output | 1 | discharge FET enable |
| sleep_req | output | 1 | sleep request |
| host_en | output | 1 | host interface enabled |
| busy | output | 1 | reset lockout running |

## Verification
Every output is a register, or decodes directly from the state register. An input that is driven before edge N therefore shows its effect in the cycle after edge N. A host write takes effect one edge after it is driven.

Delays have fixed due cycles. Sleep follows the first low sample by UV_TICKS+1 edges. Busy lasts LOCK_TICKS cycles after the wake edge. Monitor-mode release lands REL_TICKS+1 edges after cell_rel goes all ones.

The scoreboard queues each expectation with its absolute due cycle and compares it at the falling edge of that cycle. Release is probed with discharge writes placed one cycle before the due edge and again on it. This separates a correct release edge from one that comes a cycle early or late.

// File: rtl/uvp_pkg.sv
package uvp_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_DETECT,
        ST_SLEEP,
        ST_LOCK,
        ST_BLOCK,
        ST_WAIT,
        ST_RELEASE
    } uvp_state_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/uvp_cell_reduce.sv
module uvp_cell_reduce #(
    parameter int NCELL = 3
) (
    input  logic [NCELL-1:0] low_i,
    input  logic [NCELL-1:0] rel_i,
    input  logic [NCELL-1:0] ce_i,
    output logic             any_low_o,
    output logic             all_rel_o,
    output logic             all_ce_o
);
    logic [NCELL:0] low_chain;
    logic [NCELL:0] rel_chain;
    logic [NCELL:0] ce_chain;

    assign low_chain[0] = 1'b0;
    assign rel_chain[0] = 1'b1;
    assign ce_chain[0]  = 1'b1;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        assign low_chain[i+1] = low_chain[i] | low_i[i];
        assign rel_chain[i+1] = rel_chain[i] & rel_i[i];
        assign ce_chain[i+1]  = ce_chain[i]  & ce_i[i];
    end

    assign any_low_o = low_chain[NCELL];
    assign all_rel_o = rel_chain[NCELL];
    assign all_ce_o  = ce_chain[NCELL];
endmodule

// File: rtl/uvp_step_counter.sv
module uvp_step_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/uvp_fet_ctrl.sv
module uvp_fet_ctrl
    import uvp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  uvp_state_t state_i,
    input  uvp_state_t state_nxt_i,
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic       wr_val_i,
    output logic       cfet_o,
    output logic       dfet_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfet_o <= 1'b1;
            dfet_o <= 1'b1;
        end else if (state_nxt_i == ST_SLEEP || state_nxt_i == ST_LOCK ||
                     state_nxt_i == ST_BLOCK) begin
            cfet_o <= 1'b0;
            dfet_o <= 1'b0;
        end else begin
            unique case (state_i)
                ST_RUN, ST_DETECT: begin
                    if (wr_en_i && wr_sel_i)  dfet_o <= wr_val_i;
                    if (wr_en_i && !wr_sel_i) cfet_o <= wr_val_i;
                end
                ST_WAIT, ST_RELEASE: begin
                    dfet_o <= 1'b0;
                    if (wr_en_i && !wr_sel_i) cfet_o <= wr_val_i;
                end
                default: begin
                    cfet_o <= cfet_o;
                    dfet_o <= dfet_o;
                end
            endcase
        end
    end
endmodule

// File: rtl/uvp_guard.sv
module uvp_guard
    import uvp_pkg::*;
#(
    parameter int NCELL       = 3,
    parameter int UV_TICKS    = 8,
    parameter int OV_TICKS    = 6,
    parameter int GUARD_TICKS = 10,
    parameter int REL_TICKS   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCELL-1:0] cell_low,
    input  logic [NCELL-1:0] cell_rel,
    input  logic [NCELL-1:0] cell_ce_ok,
    input  logic             chg_present,
    input  logic             ce_cfg,
    input  logic             mon_mode,
    input  logic             sample_tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic             wr_val,
    output logic             cfet_on,
    output logic             dfet_on,
    output logic             sleep_req,
    output logic             host_en,
    output logic             busy
);
    localparam int LOCK_TICKS = int'(imax(OV_TICKS, UV_TICKS)) + GUARD_TICKS;
    localparam int MAXT       = int'(imax(imax(UV_TICKS, LOCK_TICKS), imax(REL_TICKS, 2)));
    localparam int CW         = $clog2(MAXT + 1);
    localparam logic [CW-1:0] UV_LAST   = CW'(UV_TICKS - 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_TICKS - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_TICKS - 1);
    localparam logic [CW-1:0] ONE_SMP   = CW'(1);

    uvp_state_t    state, state_nxt;
    logic          any_low, all_rel, all_ce;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    logic          rel_done;

    uvp_cell_reduce #(.NCELL(NCELL)) u_reduce (
        .low_i(cell_low), .rel_i(cell_rel), .ce_i(cell_ce_ok),
        .any_low_o(any_low), .all_rel_o(all_rel), .all_ce_o(all_ce)
    );

    uvp_step_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc), .cnt_o(cnt)
    );

    uvp_fet_ctrl u_fet (
        .clk(clk), .rst_n(rst_n), .state_i(state), .state_nxt_i(state_nxt),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_val_i(wr_val),
        .cfet_o(cfet_on), .dfet_o(dfet_on)
    );

    // Release qualification: timer in monitor mode, two sample ticks otherwise
    assign rel_done = mon_mode ? (cnt == REL_LAST) : (sample_tick && cnt == ONE_SMP);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:     if (any_low) state_nxt = ST_DETECT;
            ST_DETECT: begin
                if (!any_low)            state_nxt = ST_RUN;
                else if (cnt == UV_LAST) state_nxt = ST_SLEEP;
            end
            ST_SLEEP:   if (chg_present) state_nxt = ST_LOCK;
            ST_LOCK: begin
                if (cnt == LOCK_LAST) state_nxt = (ce_cfg && !all_ce) ? ST_BLOCK : ST_WAIT;
            end
            ST_BLOCK:   if (!ce_cfg) state_nxt = ST_WAIT;
            ST_WAIT:    if (all_rel) state_nxt = ST_RELEASE;
            ST_RELEASE: begin
                if (!all_rel)     state_nxt = ST_WAIT;
                else if (rel_done) state_nxt = ST_RUN;
            end
            default:    state_nxt = ST_RUN;
        endcase
    end

    assign cnt_clr = (state_nxt != state);
    assign cnt_inc = (state == ST_DETECT) || (state == ST_LOCK) ||
                     (state == ST_RELEASE && (mon_mode || sample_tick));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        sleep_req = (state == ST_SLEEP);
        host_en   = (state != ST_SLEEP);
        busy      = (state == ST_LOCK);
    end

    // R2: normal mode never jumps straight to sleep
    p_no_direct_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state != ST_SLEEP));

    // R3: asleep means both FETs open and host cut off
    p_sleep_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (!cfet_on && !dfet_on && !host_en));

    // R4: no wake without the charger
    p_stay_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !chg_present) |=> sleep_req);

    // R5: lockout keeps both FETs open
    p_lock_fets_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cfet_on && !dfet_on));

    // R6: blocked charging holds while the configuration bit is set
    p_block_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCK && ce_cfg) |=> (state == ST_BLOCK && !cfet_on && !dfet_on));

    // R8: discharge FET open in every protected awake state
    p_prot_dfet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK || state == ST_BLOCK || state == ST_WAIT || state == ST_RELEASE)
        |-> !dfet_on);

    // R9: a release-threshold drop aborts qualification
    p_release_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && !all_rel) |=> (state == ST_WAIT));

    // R11: recovery lands in normal mode with the discharge FET still open
    p_recover_dfet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && state_nxt == ST_RUN) |=> (state == ST_RUN && !dfet_on));
endmodule

// File: tb/sim_uvp_guard.sv
module sim_uvp_guard;
    localparam int NCELL = 3;
    localparam int UV    = 8;
    localparam int OV    = 6;
    localparam int GUARD = 10;
    localparam int REL   = 12;
    localparam int LOCK  = ((OV > UV) ? OV : UV) + GUARD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCELL-1:0] cell_low = '0, cell_rel = '1, cell_ce_ok = '1;
    logic chg_present = 0, ce_cfg = 0, mon_mode = 1, sample_tick = 0;
    logic wr_en = 0, wr_sel = 0, wr_val = 0;
    logic cfet_on, dfet_on, sleep_req, host_en, busy;

    always #4 clk = ~clk;

    uvp_guard #(.NCELL(NCELL), .UV_TICKS(UV), .OV_TICKS(OV),
                .GUARD_TICKS(GUARD), .REL_TICKS(REL)) u0 (
        .clk(clk), .rst_n(rst_n), .cell_low(cell_low), .cell_rel(cell_rel),
        .cell_ce_ok(cell_ce_ok), .chg_present(chg_present), .ce_cfg(ce_cfg),
        .mon_mode(mon_mode), .sample_tick(sample_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_val(wr_val), .cfet_on(cfet_on), .dfet_on(dfet_on),
        .sleep_req(sleep_req), .host_en(host_en), .busy(busy)
    );

    typedef struct {
        int         cyc;
        logic [4:0] v;
        string      tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: vector is {cfet_on, dfet_on, sleep_req, host_en, busy}
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            logic [4:0] got;
            it  = q.pop_front();
            got = {cfet_on, dfet_on, sleep_req, host_en, busy};
            total++;
            if (got !== it.v) begin
                bad++;
                $display("FAIL %s: cycle %0d got %b expected %b", it.tag, cyc, got, it.v);
            end
        end
    end

    task automatic want(input int k, input logic [4:0] v, input string tag);
        item_t it;
        it.cyc = cyc + k;
        it.v   = v;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_pulse(input logic sel, input logic val, input int len);
        wr_en = 1; wr_sel = sel; wr_val = val;
        tick(len);
        wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1 reset state
        want(1, 5'b11010, "R1 reset outputs");
        tick(2);

        // R2 short dip aborts
        cell_low = 3'b010;
        want(UV, 5'b11010, "R2 detect still normal");
        tick(UV);
        cell_low = '0;
        want(1, 5'b11010, "R2 abort before expiry");
        want(4, 5'b11010, "R2 still normal");
        tick(4);

        // R3 qualified fault
        cell_rel = 3'b011;
        cell_low = 3'b100;
        want(UV, 5'b11010, "R2 counting");
        want(UV + 1, 5'b00100, "R3 protection entry");
        tick(UV + 1);
        cell_low = '0;
        want(5, 5'b00100, "R4 asleep without charger");
        tick(5);

        // R4 wake, R5 lockout
        chg_present = 1; ce_cfg = 1; cell_ce_ok = 3'b011;
        want(1, 5'b00011, "R4 wake host on dfet off");
        tick(2);
        wr_pulse(1'b0, 1'b1, 1);
        want(2, 5'b00011, "R5 write ignored in lockout");
        want(LOCK - 3, 5'b00011, "R5 busy last cycle");
        want(LOCK - 2, 5'b00010, "R5 lockout length");
        tick(LOCK - 2);

        // R6 blocked charging
        wr_en = 1; wr_sel = 0; wr_val = 1;
        want(1, 5'b00010, "R6 charge write blocked");
        tick(1);
        wr_en = 0;
        want(3, 5'b00010, "R6 held off");
        tick(3);
        ce_cfg = 0;
        tick(1);

        // R7 charge enable, R8 discharge ignored
        wr_en = 1; wr_sel = 0; wr_val = 1;
        want(1, 5'b10010, "R7 charge fet on");
        tick(1);
        wr_sel = 1;
        want(1, 5'b10010, "R8 discharge write no effect");
        want(2, 5'b10010, "R8 discharge still off");
        tick(1);
        wr_en = 0;
        tick(1);

        // R9 monitor release with a restart
        cell_rel = '1;
        tick(4);
        cell_rel = 3'b011;
        tick(2);
        cell_rel = '1;
        tick(REL);
        wr_en = 1; wr_sel = 1; wr_val = 1;
        want(1, 5'b10010, "R9 not released before delay");
        tick(1);
        want(1, 5'b11010, "R9 released, R11 discharge write accepted");
        tick(1);
        wr_en = 0;
        chg_present = 0;
        want(1, 5'b11010, "R11 charger loss no sleep");
        want(6, 5'b11010, "R11 still normal");
        tick(6);

        // R10 non-monitor recovery
        mon_mode = 0;
        cell_rel = 3'b011;
        cell_low = 3'b001;
        want(UV + 1, 5'b00100, "R3 second entry");
        tick(UV + 1);
        cell_low = '0; chg_present = 1; ce_cfg = 1; cell_ce_ok = '1;
        want(LOCK, 5'b00011, "R5 second lockout");
        want(LOCK + 1, 5'b00010, "R6 charge-enable ok goes awake");
        tick(LOCK + 1);
        cell_rel = '1;
        tick(2);
        sample_tick = 1;
        tick(1);
        sample_tick = 0;
        tick(1);
        wr_en = 1; wr_sel = 1; wr_val = 1;
        want(1, 5'b00010, "R10 one sample not enough");
        tick(1);
        wr_en = 0;
        tick(1);
        sample_tick = 1;
        tick(1);
        sample_tick = 0;
        wr_en = 1; wr_sel = 1; wr_val = 1;
        want(1, 5'b01010, "R10 two samples release, R11 charge unchanged");
        tick(1);
        wr_en = 0;
        tick(3);

        while (q.size() > 0) tick(1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule